// File: doc/BRIEF.md
# Engine Power Enable and Clamp Register Block

This block is the hardware side of the bring-up sequence for a graphics engine that may start out power-gated. It holds three memory-mapped control registers. The first switches the graphics engine on and turns on the block-level power and clock gating controllers. The second selects the isolation clamp from a mask and a value. The third lets software override the boot-time power-gate strap. From these registers it drives four registered outputs: an active-high engine reset, a gating-controller enable, the engine clamp and the power-gate request.

A simple single-cycle register bus reaches the registers. A write takes effect on the clock edge that samples it. A read returns its data one cycle later, together with a valid strobe. An access to an address that no register decodes raises a one-cycle error pulse. A read of such an address returns zero.

Software turns the engine on with read-modify-write steps. It holds the engine in reset and enables gating. It forces the clamp to 1 and then lets it go. It overrides the boot gate to off. It forces the clamp to 0 and then lets it go. It then disables gating and releases the engine. Because every register bit reads back exactly what was written, these read-modify-write steps work without extra logic.

Top module: `eng_power_ctl`

## Requirements
- R1: After synchronous reset every register reads 0. The outputs are then eng_reset=1, gating_ctl_en=0, eng_clamp equal to hw_clamp_dflt, and pwr_gate_req equal to boot_gate_strap.
- R2: The engine register is at byte address 0x200. Its bit 12 is the graphics engine enable and its bit 27 is the gating-controller enable. gating_ctl_en equals bit 27.
- R3: eng_reset is 1 whenever engine register bit 12 is 0, and 0 when it is 1. A disabled engine is held in reset.
- R4: The switch-mask register is at byte address 0x10A78C. Bit 0 is the clamp mask and bit 1 is the clamp value.
- R5: When the clamp mask is 1, eng_clamp equals the clamp value. When the mask is 0, eng_clamp follows hw_clamp_dflt.
- R6: The thermal register is at byte address 0x20004. Bit 30 is the boot-gate override enable and bit 31 is the override value, where 1 means gate on.
- R7: pwr_gate_req equals boot_gate_strap while the override enable is 0, and equals the override value while it is 1.
- R8: Register bits other than those named in R2, R4 and R6 read as 0 and ignore written data.
- R9: A read of an unmapped address returns rdata 0. Any access to an unmapped address raises bus_decerr for exactly one cycle and changes no register.
- R10: A write changes its register at the clock edge that samples the request, and the outputs follow at the next edge. A read gives bus_rvalid=1 with its data in the cycle after the request, for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read-data strobe |
| bus_decerr | output | 1 | One-cycle pulse for an unmapped access |
| hw_clamp_dflt | input | 1 | Clamp level used while the mask is clear |
| boot_gate_strap | input | 1 | Boot-time power-gate strap |
| eng_reset | output | 1 | Active-high graphics engine reset |
| gating_ctl_en | output | 1 | Block-level power/clock gating controller enable |
| eng_clamp | output | 1 | Engine isolation clamp |
| pwr_gate_req | output | 1 | Power-gate request |

## Verification
Suppose a register bit is stuck, is decoded at the wrong address, or has the wrong mask. The next read of that register then returns a value different from the model, one cycle after the read request. The output tied to that bit also differs from the model two edges after the write. A wrong select in the clamp or gate multiplexer shows up on eng_clamp or pwr_gate_req one edge after the hardware input toggles. Random traffic that mixes mapped, unmapped and adjacent addresses exposes any aliasing in the decoder through bus_decerr or a corrupted read-back.

// File: rtl/eng_power_pkg.sv
package eng_power_pkg;
  localparam int DW   = 32;
  localparam int NREG = 3;

  // register slots
  localparam int SLOT_ENG = 0;
  localparam int SLOT_SW  = 1;
  localparam int SLOT_TH  = 2;

  // field positions (software decodes these)
  localparam int B_GFX_EN   = 12;
  localparam int B_GATE_EN  = 27;
  localparam int B_CLMP_MSK = 0;
  localparam int B_CLMP_VAL = 1;
  localparam int B_OVR_EN   = 30;
  localparam int B_OVR_VAL  = 31;

  localparam logic [31:0] OFS_ENG = 32'h0000_0200;
  localparam logic [31:0] OFS_SW  = 32'h0010_A78C;
  localparam logic [31:0] OFS_TH  = 32'h0002_0004;

  function automatic logic [DW-1:0] bitmask(input int pos);
    logic [DW-1:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  function automatic logic [NREG*DW-1:0] all_masks();
    logic [NREG*DW-1:0] v;
    v = '0;
    v[SLOT_ENG*DW +: DW] = bitmask(B_GFX_EN) | bitmask(B_GATE_EN);
    v[SLOT_SW*DW  +: DW] = bitmask(B_CLMP_MSK) | bitmask(B_CLMP_VAL);
    v[SLOT_TH*DW  +: DW] = bitmask(B_OVR_EN) | bitmask(B_OVR_VAL);
    return v;
  endfunction
endpackage

// File: rtl/eng_power_decode.sv
module eng_power_decode #(
  parameter int ADDR_W = 24,
  parameter int NREG   = 3,
  parameter logic [NREG*ADDR_W-1:0] OFS_VEC = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit,
  output logic              miss
);
  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign hit[i] = (addr == OFS_VEC[i*ADDR_W +: ADDR_W]);
  end
  assign miss = ~|hit;
endmodule

// File: rtl/eng_power_regfile.sv
module eng_power_regfile
  import eng_power_pkg::*;
#(
  parameter int NREG_P = NREG,
  parameter logic [NREG_P*DW-1:0] MASK_VEC = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic [NREG_P-1:0]    hit,
  input  logic [DW-1:0]        wdata,
  output logic [NREG_P*DW-1:0] regs
);
  for (genvar i = 0; i < NREG_P; i++) begin : g_reg
    localparam logic [DW-1:0] MSK = MASK_VEC[i*DW +: DW];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (wr_stb && hit[i])
        q <= wdata & MSK;
    end
    assign regs[i*DW +: DW] = q;
  end
endmodule

// File: rtl/eng_power_rdport.sv
module eng_power_rdport
  import eng_power_pkg::*;
#(
  parameter int NREG_P = NREG
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 wr,
  input  logic [NREG_P-1:0]    hit,
  input  logic                 miss,
  input  logic [NREG_P*DW-1:0] regs,
  output logic [DW-1:0]        rdata,
  output logic                 rvalid,
  output logic                 decerr
);
  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG_P; i++)
      if (hit[i]) rd_mux = rd_mux | regs[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      decerr <= 1'b0;
    end else begin
      rvalid <= sel && !wr;
      decerr <= sel && miss;
      if (sel && !wr) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/eng_power_outs.sv
module eng_power_outs (
  input  logic clk,
  input  logic rst,
  input  logic gfx_en,
  input  logic gate_en,
  input  logic clmp_msk,
  input  logic clmp_val,
  input  logic ovr_en,
  input  logic ovr_val,
  input  logic hw_clamp_dflt,
  input  logic boot_gate_strap,
  output logic eng_reset,
  output logic gating_ctl_en,
  output logic eng_clamp,
  output logic pwr_gate_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      eng_reset     <= 1'b1;
      gating_ctl_en <= 1'b0;
      eng_clamp     <= hw_clamp_dflt;
      pwr_gate_req  <= boot_gate_strap;
    end else begin
      eng_reset     <= !gfx_en;
      gating_ctl_en <= gate_en;
      eng_clamp     <= clmp_msk ? clmp_val : hw_clamp_dflt;
      pwr_gate_req  <= ovr_en ? ovr_val : boot_gate_strap;
    end
  end
endmodule

// File: rtl/eng_power_ctl.sv
module eng_power_ctl
  import eng_power_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] ENG_ADDR = OFS_ENG[ADDR_W-1:0],
  parameter logic [ADDR_W-1:0] SW_ADDR  = OFS_SW[ADDR_W-1:0],
  parameter logic [ADDR_W-1:0] TH_ADDR  = OFS_TH[ADDR_W-1:0]
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_decerr,
  input  logic              hw_clamp_dflt,
  input  logic              boot_gate_strap,
  output logic              eng_reset,
  output logic              gating_ctl_en,
  output logic              eng_clamp,
  output logic              pwr_gate_req
);
  localparam logic [NREG*ADDR_W-1:0] OFS_VEC = {TH_ADDR, SW_ADDR, ENG_ADDR};
  localparam logic [NREG*DW-1:0]     MASKS   = all_masks();

  logic [NREG-1:0]    hit;
  logic               miss;
  logic [NREG*DW-1:0] regs;
  logic [DW-1:0]      r_eng, r_sw, r_th;

  eng_power_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .OFS_VEC(OFS_VEC)) u_dec (
    .addr(bus_addr), .hit(hit), .miss(miss)
  );

  eng_power_regfile #(.NREG_P(NREG), .MASK_VEC(MASKS)) u_rf (
    .clk(clk), .rst(rst), .wr_stb(bus_sel && bus_wr), .hit(hit),
    .wdata(bus_wdata), .regs(regs)
  );

  eng_power_rdport #(.NREG_P(NREG)) u_rd (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .hit(hit), .miss(miss),
    .regs(regs), .rdata(bus_rdata), .rvalid(bus_rvalid), .decerr(bus_decerr)
  );

  assign r_eng = regs[SLOT_ENG*DW +: DW];
  assign r_sw  = regs[SLOT_SW*DW  +: DW];
  assign r_th  = regs[SLOT_TH*DW  +: DW];

  eng_power_outs u_out (
    .clk(clk), .rst(rst),
    .gfx_en(r_eng[B_GFX_EN]), .gate_en(r_eng[B_GATE_EN]),
    .clmp_msk(r_sw[B_CLMP_MSK]), .clmp_val(r_sw[B_CLMP_VAL]),
    .ovr_en(r_th[B_OVR_EN]), .ovr_val(r_th[B_OVR_VAL]),
    .hw_clamp_dflt(hw_clamp_dflt), .boot_gate_strap(boot_gate_strap),
    .eng_reset(eng_reset), .gating_ctl_en(gating_ctl_en),
    .eng_clamp(eng_clamp), .pwr_gate_req(pwr_gate_req)
  );
endmodule

// File: rtl/eng_power_ctl_chk.sv
module eng_power_ctl_chk #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] ENG_ADDR = 24'h000200,
  parameter logic [ADDR_W-1:0] SW_ADDR  = 24'h10A78C,
  parameter logic [ADDR_W-1:0] TH_ADDR  = 24'h020004
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              bus_decerr,
  input logic              hw_clamp_dflt,
  input logic              boot_gate_strap,
  input logic              eng_reset,
  input logic              gating_ctl_en,
  input logic              eng_clamp,
  input logic              pwr_gate_req
);
  localparam logic [31:0] USED = 32'hC800_1003;
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  logic wr_eng, wr_sw, wr_th, mapped;
  assign wr_eng = bus_sel && bus_wr && bus_addr == ENG_ADDR;
  assign wr_sw  = bus_sel && bus_wr && bus_addr == SW_ADDR;
  assign wr_th  = bus_sel && bus_wr && bus_addr == TH_ADDR;
  assign mapped = bus_addr == ENG_ADDR || bus_addr == SW_ADDR || bus_addr == TH_ADDR;

  // R10
  rd_valid_next_chk: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !bus_wr |=> bus_rvalid);
  // R10
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> !bus_rvalid && !bus_decerr);
  // R9
  decerr_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !bus_wr && !mapped |=> bus_decerr && bus_rdata == 32'h0);
  // R8
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (bus_rdata & ~USED) == 32'h0);
  // R3
  reset_follows_en_chk: assert property (@(posedge clk) disable iff (rst)
    wr_eng |=> ##1 eng_reset == !$past(bus_wdata[12], 2));
  // R2
  gate_en_follows_chk: assert property (@(posedge clk) disable iff (rst)
    wr_eng |=> ##1 gating_ctl_en == $past(bus_wdata[27], 2));
  // R5
  clamp_forced_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sw && bus_wdata[0] |=> ##1 eng_clamp == $past(bus_wdata[1], 2));
  // R5
  clamp_default_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sw && !bus_wdata[0] |=> ##1 eng_clamp == $past(hw_clamp_dflt, 1));
  // R7
  gate_override_chk: assert property (@(posedge clk) disable iff (rst)
    wr_th && bus_wdata[30] |=> ##1 pwr_gate_req == $past(bus_wdata[31], 2));
  // R7
  gate_strap_chk: assert property (@(posedge clk) disable iff (rst)
    wr_th && !bus_wdata[30] |=> ##1 pwr_gate_req == $past(boot_gate_strap, 1));
endmodule

bind eng_power_ctl eng_power_ctl_chk #(
  .ADDR_W(ADDR_W), .ENG_ADDR(ENG_ADDR), .SW_ADDR(SW_ADDR), .TH_ADDR(TH_ADDR)
) u_chk (.*);

// File: tb/eng_power_ctl_bench.sv
module eng_power_ctl_bench;
  localparam int AW = 24;
  localparam logic [AW-1:0] A_ENG = 24'h000200;
  localparam logic [AW-1:0] A_SW  = 24'h10A78C;
  localparam logic [AW-1:0] A_TH  = 24'h020004;
  localparam logic [31:0] M_ENG = 32'h0800_1000;
  localparam logic [31:0] M_SW  = 32'h0000_0003;
  localparam logic [31:0] M_TH  = 32'hC000_0000;

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, bus_decerr;
  logic hw_clamp_dflt = 0, boot_gate_strap = 1;
  logic eng_reset, gating_ctl_en, eng_clamp, pwr_gate_req;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_eng = 0, m_sw = 0, m_th = 0;
  logic [31:0] rd_d;
  logic rd_v, rd_e;

  always #2.5 clk = ~clk;

  eng_power_ctl u_eng_power_ctl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    if (a == A_ENG) return m_eng;
    if (a == A_SW) return m_sw;
    if (a == A_TH) return m_th;
    return 32'h0;
  endfunction

  function automatic logic is_mapped(input logic [AW-1:0] a);
    return a == A_ENG || a == A_SW || a == A_TH;
  endfunction

  function automatic logic exp_clamp();
    return m_sw[0] ? m_sw[1] : hw_clamp_dflt;
  endfunction

  function automatic logic exp_gate();
    return m_th[30] ? m_th[31] : boot_gate_strap;
  endfunction

  // one access; returns strobes sampled the cycle after the request
  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    rd_d = bus_rdata; rd_v = bus_rvalid; rd_e = bus_decerr;
    if (wr) begin
      if (a == A_ENG) m_eng = d & M_ENG;
      if (a == A_SW)  m_sw  = d & M_SW;
      if (a == A_TH)  m_th  = d & M_TH;
    end
  endtask

  task automatic check_outs(input string tag);
    @(negedge clk);
    chk({tag, " R3 eng_reset"}, {31'b0, eng_reset}, {31'b0, !m_eng[12]});
    chk({tag, " R2 gating_ctl_en"}, {31'b0, gating_ctl_en}, {31'b0, m_eng[27]});
    chk({tag, " R5 eng_clamp"}, {31'b0, eng_clamp}, {31'b0, exp_clamp()});
    chk({tag, " R7 pwr_gate_req"}, {31'b0, pwr_gate_req}, {31'b0, exp_gate()});
  endtask

  task automatic wr_chk(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    access(1, a, d);
    chk({tag, " R9 write decerr"}, {31'b0, rd_e}, {31'b0, !is_mapped(a)});
    chk({tag, " R10 no rvalid on write"}, {31'b0, rd_v}, 32'h0);
    check_outs(tag);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string tag);
    access(0, a, 32'h0);
    chk({tag, " R10 rvalid"}, {31'b0, rd_v}, 32'h1);
    chk({tag, " R8 R9 rdata"}, rd_d, exp_read(a));
    chk({tag, " R9 read decerr"}, {31'b0, rd_e}, {31'b0, !is_mapped(a)});
  endtask

  logic done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 eng_reset", {31'b0, eng_reset}, 32'h1);
    chk("R1 gating_ctl_en", {31'b0, gating_ctl_en}, 32'h0);
    chk("R1 eng_clamp", {31'b0, eng_clamp}, {31'b0, hw_clamp_dflt});
    chk("R1 pwr_gate_req", {31'b0, pwr_gate_req}, {31'b0, boot_gate_strap});
    rd_chk(A_ENG, "R1 eng reg");
    rd_chk(A_SW, "R1 sw reg");
    rd_chk(A_TH, "R1 th reg");

    // R10: rvalid lasts one cycle
    access(0, A_ENG, 0);
    @(negedge clk);
    chk("R10 rvalid one cycle", {31'b0, bus_rvalid}, 32'h0);

    // bring-up order, R2 R3 R4 R5 R6 R7
    wr_chk(A_ENG, 32'h0, "seq disable");
    rd_chk(A_ENG, "seq R2 readback");
    wr_chk(A_ENG, 32'h0800_0000, "seq R2 gate on");
    wr_chk(A_SW, 32'h2, "seq R4 val1");
    wr_chk(A_SW, 32'h3, "seq R5 force1");
    wr_chk(A_SW, 32'h2, "seq R5 release");
    wr_chk(A_TH, 32'h0, "seq R6 value off");
    wr_chk(A_TH, 32'h4000_0000, "seq R7 override off");
    wr_chk(A_SW, 32'h1, "seq R5 force0");
    wr_chk(A_SW, 32'h0, "seq R5 release0");
    wr_chk(A_ENG, 32'h0, "seq R2 gate off");
    wr_chk(A_ENG, 32'h0000_1000, "seq R3 engine on");
    rd_chk(A_ENG, "seq R3 readback");

    // R8 all-ones writes keep only named bits
    wr_chk(A_ENG, 32'hFFFF_FFFF, "R8 eng ones");
    rd_chk(A_ENG, "R8 eng ones rd");
    wr_chk(A_SW, 32'hFFFF_FFFF, "R8 sw ones");
    rd_chk(A_SW, "R8 sw ones rd");
    wr_chk(A_TH, 32'hFFFF_FFFF, "R8 th ones");
    rd_chk(A_TH, "R8 th ones rd");

    // R9 neighbouring unmapped addresses
    wr_chk(A_ENG + 24'd1, 32'h0, "R9 near eng wr");
    wr_chk(A_SW + 24'd4, 32'h0, "R9 near sw wr");
    rd_chk(A_TH - 24'd4, "R9 near th rd");
    rd_chk(A_ENG, "R9 eng intact");
    rd_chk(A_SW, "R9 sw intact");
    rd_chk(A_TH, "R9 th intact");

    // R5 R7 input following with mask/override clear
    wr_chk(A_SW, 32'h0, "R5 mask clear");
    wr_chk(A_TH, 32'h0, "R7 ovr clear");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      hw_clamp_dflt = k[0]; boot_gate_strap = k[1];
      @(negedge clk);
      chk("R5 follows hw", {31'b0, eng_clamp}, {31'b0, k[0]});
      chk("R7 follows strap", {31'b0, pwr_gate_req}, {31'b0, k[1]});
    end

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      int pick;
      pick = $urandom_range(0, 4);
      case (pick)
        0: a = A_ENG;
        1: a = A_SW;
        2: a = A_TH;
        default: a = AW'($urandom);
      endcase
      d = $urandom;
      hw_clamp_dflt = 1'($urandom);
      boot_gate_strap = 1'($urandom);
      if ($urandom_range(0, 1) == 1) wr_chk(a, d, "rnd R10 write");
      else begin
        rd_chk(a, "rnd R10 read");
        check_outs("rnd R1");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule